// File: doc/BRIEF.md
# Cache Line Refill Sequencer

This block moves one eight-word cache line from main memory into the cache data array after a miss has been declared elsewhere. A single request carries the line address and a mode bit. In plain mode the block talks to one memory module and fetches the words one at a time: it strobes the word address, waits for the module's ready pulse, and writes the word into the cache. In interleaved mode the memory is built from four modules. Word `k` of a line sits in module `k[1:0]`. The block strobes all four modules together, so their access times overlap, gathers the whole line into a local buffer, and then writes the cache at one word per cycle.

Each memory module answers a strobe with a one-cycle ready pulse that carries the data. The module latency is set by the memory. With the eight-cycle modules the system is sized for, a refill costs 72 cycles in plain mode and 17 cycles in interleaved mode. `busy` covers the whole refill. `done` marks its end. Requests that arrive while a refill is running are dropped. Tag lookup, victim choice and write-back of dirty data belong to other blocks.

Top module: `refill_seq`

## Requirements
- R1: While reset is applied and until the first request is accepted, `busy`, `done`, `cwr_en` and all `mem_stb` bits are low.
- R2: In plain mode only module 0 is strobed. There is one strobe per word, with `mem_addr` for module 0 equal to `line*8 + word`. The next word's strobe comes in the cycle after the previous word's cache write.
- R3: In plain mode each word is written to the cache in the cycle after its ready pulse. With a memory whose ready pulse arrives 7 cycles after the strobe cycle, `done` is high 72 cycles after the edge that accepts the request.
- R4: In interleaved mode word `k` belongs to module `k mod 4` (the two low word-index bits). All four strobes are high in the two cycles right after acceptance. In the first cycle each module gets local address `line*2 + 0`, and in the second it gets `line*2 + 1`, so module `m` at local address `a` holds line word `a*4 + m - line*8`.
- R5: In interleaved mode the first cache write happens in the cycle after the eighth word arrives, and the writes then follow on back-to-back cycles. With the same 8-cycle memory, `done` is high 17 cycles after the accepting edge.
- R6: Cache writes go in ascending word order 0 to 7. `cwr_idx` is the word index and `cwr_data` is the word the memory returned for that index.
- R7: `done` is a one-cycle pulse in the cycle after the last cache write, with `busy` already low. `busy` is high from the cycle after acceptance through the last write. `cwr_en` is never high while `busy` is low.
- R8: A request seen while `busy` is high is ignored. The running refill keeps its line address and mode, and no extra strobe or write appears. A request in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Refill request, sampled while idle |
| req_line | input | 10 | Line address of the missing line |
| req_ilv | input | 1 | 1 selects interleaved memory, 0 selects a single module |
| mem_rdy | input | 4 | Per-module one-cycle data-ready pulse |
| mem_rdata | input | 128 | Per-module read data, module m at bits [m*32 +: 32] |
| mem_stb | output | 4 | Per-module access strobe |
| mem_addr | output | 52 | Per-module word address, module m at bits [m*13 +: 13] |
| cwr_en | output | 1 | Cache data-array write enable |
| cwr_idx | output | 3 | Word index within the line |
| cwr_data | output | 32 | Word written to the cache |
| busy | output | 1 | Refill in progress |
| done | output | 1 | One-cycle end-of-refill pulse |

## Verification
Strobes are due in the first cycle after acceptance: for plain mode they then recur every 9 cycles, and for interleaved mode the second strobe follows on the next cycle. Ready pulses come back 7 cycles after each strobe cycle. A plain-mode write falls 8 cycles after its strobe, and interleaved writes run from the 9th to the 16th cycle after acceptance. `done` then follows in cycle 72 or cycle 17. The bench keeps a slot counter that is independent of the design. It computes every expected output for each slot from the time since acceptance, and compares the outputs at the falling edge, half a period away from the edge where the registers change. The latency is counted from the slot in which the bench raised the request to the slot in which `done` is first seen.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [2:0] {
    RF_IDLE,
    RF_P_ADDR,
    RF_P_WAIT,
    RF_P_WR,
    RF_I_ISSUE,
    RF_I_COLLECT,
    RF_I_WR
  } rf_state_e;

endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int LINE_AW = 10,
  parameter int WORDS   = 8,
  parameter int BANKS   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [LINE_AW-1:0]          req_line,
  input  logic                        req_ilv,
  input  logic                        rdy0,
  input  logic                        fill_last,
  output rf_state_e                   state_o,
  output logic [$clog2(WORDS)-1:0]    widx_o,
  output logic [((WORDS/BANKS) > 1 ? $clog2(WORDS/BANKS) : 1)-1:0] beat_o,
  output logic [LINE_AW-1:0]          line_o,
  output logic                        busy,
  output logic                        done,
  output logic                        cwr_en
);

  localparam int WIDX_W = $clog2(WORDS);
  localparam int BEATS  = WORDS / BANKS;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(WORDS - 1);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BEATS - 1);

  rf_state_e           state_q, state_n;
  logic [WIDX_W-1:0]   widx_q, widx_n;
  logic [BEAT_W-1:0]   beat_q, beat_n;
  logic [LINE_AW-1:0]  line_q;
  logic                line_en;
  logic                done_q, done_n;

  // next-state logic
  always_comb begin
    state_n = state_q;
    widx_n  = widx_q;
    beat_n  = beat_q;
    line_en = 1'b0;
    done_n  = 1'b0;
    unique case (state_q)
      RF_IDLE: begin
        if (req_valid) begin
          line_en = 1'b1;
          widx_n  = '0;
          beat_n  = '0;
          state_n = req_ilv ? RF_I_ISSUE : RF_P_ADDR;
        end
      end
      RF_P_ADDR: state_n = RF_P_WAIT;
      RF_P_WAIT: begin
        if (rdy0) state_n = RF_P_WR;
      end
      RF_P_WR: begin
        if (widx_q == WIDX_LAST) begin
          state_n = RF_IDLE;
          done_n  = 1'b1;
        end else begin
          widx_n  = widx_q + 1'b1;
          state_n = RF_P_ADDR;
        end
      end
      RF_I_ISSUE: begin
        if (beat_q == BEAT_LAST) state_n = RF_I_COLLECT;
        else                     beat_n  = beat_q + 1'b1;
      end
      RF_I_COLLECT: begin
        if (fill_last) state_n = RF_I_WR;
      end
      RF_I_WR: begin
        if (widx_q == WIDX_LAST) begin
          state_n = RF_IDLE;
          done_n  = 1'b1;
        end else begin
          widx_n  = widx_q + 1'b1;
        end
      end
      default: state_n = RF_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RF_IDLE;
      widx_q  <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      widx_q  <= widx_n;
      beat_q  <= beat_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= req_line;
  end

  assign state_o = state_q;
  assign widx_o  = widx_q;
  assign beat_o  = beat_q;
  assign line_o  = line_q;
  assign busy    = (state_q != RF_IDLE);
  assign done    = done_q;
  assign cwr_en  = (state_q == RF_P_WR) || (state_q == RF_I_WR);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cwr_en) && !busy)); // R7
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cwr_en); // R7
  AST_WRITE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_en && $past(cwr_en)) |-> (widx_q == $past(widx_q) + 1'b1)); // R6
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(line_q)); // R8

endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
  parameter int DW    = 32,
  parameter int WORDS = 8,
  parameter int BANKS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     plain_cap,
  input  logic [$clog2(WORDS)-1:0] plain_idx,
  input  logic                     ilv_en,
  input  logic [BANKS-1:0]         rdy,
  input  logic [BANKS*DW-1:0]      rdata,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic                     fill_last
);

  localparam int WIDX_W = $clog2(WORDS);
  localparam int CNT_W  = WIDX_W + 1;
  localparam int BEATS  = WORDS / BANKS;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [DW-1:0]      word_q [WORDS];
  logic [BEAT_W-1:0]  bcnt_q [BANKS];
  logic [CNT_W-1:0]   cnt_q;
  logic [BANKS-1:0]   take;
  logic [CNT_W-1:0]   incoming;

  assign take      = rdy & {BANKS{ilv_en}};
  assign incoming  = CNT_W'($countones(take));
  assign fill_last = ilv_en && ((cnt_q + incoming) == CNT_W'(WORDS));

  // per-module beat counters: which of the module's words arrives next
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bcnt_q[b] <= '0;
      else if (clr)     bcnt_q[b] <= '0;
      else if (take[b]) bcnt_q[b] <= bcnt_q[b] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ilv_en) cnt_q <= cnt_q + incoming;
  end

  // line storage: word w lives in module w mod BANKS, beat w / BANKS
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int BK = w % BANKS;
    localparam int BT = w / BANKS;
    logic we_plain, we_ilv;
    assign we_plain = plain_cap && (plain_idx == WIDX_W'(w));
    assign we_ilv   = take[BK] && (bcnt_q[BK] == BEAT_W'(BT));
    always_ff @(posedge clk) begin
      if (we_plain)    word_q[w] <= rdata[0 +: DW];
      else if (we_ilv) word_q[w] <= rdata[BK*DW +: DW];
    end
  end

  assign rd_data = word_q[rd_idx];

  AST_CAPTURE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ilv_en |-> (cnt_q < CNT_W'(WORDS))); // R5
  AST_FILL_THEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> !ilv_en); // R5

endmodule

// File: rtl/refill_addrgen.sv
module refill_addrgen
  import refill_pkg::*;
#(
  parameter int LINE_AW = 10,
  parameter int WORDS   = 8,
  parameter int BANKS   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  rf_state_e                  state_i,
  input  logic [LINE_AW-1:0]         line_i,
  input  logic [$clog2(WORDS)-1:0]   widx_i,
  input  logic [((WORDS/BANKS) > 1 ? $clog2(WORDS/BANKS) : 1)-1:0] beat_i,
  output logic [BANKS-1:0]           mem_stb,
  output logic [BANKS*(LINE_AW+$clog2(WORDS))-1:0] mem_addr
);

  localparam int WIDX_W = $clog2(WORDS);
  localparam int MAW    = LINE_AW + WIDX_W;
  localparam int BEATS  = WORDS / BANKS;

  logic              plain_issue, ilv_issue;
  logic [MAW-1:0]    plain_addr, bank_addr;

  assign plain_issue = (state_i == RF_P_ADDR);
  assign ilv_issue   = (state_i == RF_I_ISSUE);
  assign plain_addr  = {line_i, widx_i};
  assign bank_addr   = MAW'(line_i) * MAW'(BEATS) + MAW'(beat_i);

  for (genvar b = 0; b < BANKS; b++) begin : g_port
    if (b == 0) begin : g_home
      assign mem_stb[b]            = plain_issue || ilv_issue;
      assign mem_addr[b*MAW +: MAW] = ilv_issue ? bank_addr : plain_addr;
    end else begin : g_other
      assign mem_stb[b]            = ilv_issue;
      assign mem_addr[b*MAW +: MAW] = bank_addr;
    end
  end

  AST_PLAIN_SINGLE_MODULE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i inside {RF_P_ADDR, RF_P_WAIT, RF_P_WR}) |-> (mem_stb[BANKS-1:1] == '0)); // R2
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == RF_IDLE) |-> (mem_stb == '0)); // R1
  AST_ILV_ALL_MODULES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_stb[BANKS-1] == 1'b1) |-> (mem_stb == '1)); // R4

endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int DW      = 32,
  parameter int LINE_AW = 10,
  parameter int WORDS   = 8,
  parameter int BANKS   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [LINE_AW-1:0]         req_line,
  input  logic                       req_ilv,
  input  logic [BANKS-1:0]           mem_rdy,
  input  logic [BANKS*DW-1:0]        mem_rdata,
  output logic [BANKS-1:0]           mem_stb,
  output logic [BANKS*(LINE_AW+$clog2(WORDS))-1:0] mem_addr,
  output logic                       cwr_en,
  output logic [$clog2(WORDS)-1:0]   cwr_idx,
  output logic [DW-1:0]              cwr_data,
  output logic                       busy,
  output logic                       done
);

  localparam int WIDX_W = $clog2(WORDS);
  localparam int BEATS  = WORDS / BANKS;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rf_state_e          state;
  logic [WIDX_W-1:0]  widx;
  logic [BEAT_W-1:0]  beat;
  logic [LINE_AW-1:0] line;
  logic               fill_last;
  logic               plain_cap, ilv_en, clr;

  assign plain_cap = (state == RF_P_WAIT) && mem_rdy[0];
  assign ilv_en    = (state == RF_I_ISSUE) || (state == RF_I_COLLECT);
  assign clr       = (state == RF_IDLE);

  refill_ctrl #(.LINE_AW(LINE_AW), .WORDS(WORDS), .BANKS(BANKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_line  (req_line),
    .req_ilv   (req_ilv),
    .rdy0      (mem_rdy[0]),
    .fill_last (fill_last),
    .state_o   (state),
    .widx_o    (widx),
    .beat_o    (beat),
    .line_o    (line),
    .busy      (busy),
    .done      (done),
    .cwr_en    (cwr_en)
  );

  refill_linebuf #(.DW(DW), .WORDS(WORDS), .BANKS(BANKS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .plain_cap (plain_cap),
    .plain_idx (widx),
    .ilv_en    (ilv_en),
    .rdy       (mem_rdy),
    .rdata     (mem_rdata),
    .rd_idx    (widx),
    .rd_data   (cwr_data),
    .fill_last (fill_last)
  );

  refill_addrgen #(.LINE_AW(LINE_AW), .WORDS(WORDS), .BANKS(BANKS)) u_addr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .state_i  (state),
    .line_i   (line),
    .widx_i   (widx),
    .beat_i   (beat),
    .mem_stb  (mem_stb),
    .mem_addr (mem_addr)
  );

  assign cwr_idx = widx;

endmodule

// File: tb/refill_seq_test.sv
module refill_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW      = 32;
  localparam int LINE_AW = 10;
  localparam int WORDS   = 8;
  localparam int BANKS   = 4;
  localparam int MAW     = 13;
  localparam int MEM_LAT = 7;   // ready pulse this many cycles after the strobe cycle
  localparam int END_P   = 72;
  localparam int END_I   = 17;

  logic                   clk;
  logic                   rst_n;
  logic                   req_valid;
  logic [LINE_AW-1:0]     req_line;
  logic                   req_ilv;
  logic [BANKS-1:0]       mem_rdy;
  logic [BANKS*DW-1:0]    mem_rdata;
  logic [BANKS-1:0]       mem_stb;
  logic [BANKS*MAW-1:0]   mem_addr;
  logic                   cwr_en;
  logic [2:0]             cwr_idx;
  logic [DW-1:0]          cwr_data;
  logic                   busy;
  logic                   done;

  refill_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_ilv(req_ilv), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .mem_stb(mem_stb), .mem_addr(mem_addr), .cwr_en(cwr_en),
    .cwr_idx(cwr_idx), .cwr_data(cwr_data), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference model state
  int n_slot  = 0;
  int m_t     = -1;
  int m_ilv   = 0;
  int m_line  = 0;
  int m_acc   = 0;
  int m_end   = END_P;

  // memory model
  int pend_due[$];
  int pend_bank[$];
  int pend_g[$];

  function automatic logic [31:0] memf(int g);
    logic [31:0] x;
    x = 32'(g);
    return (x * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s slot %0d actual %0h expected %0h", req, what, n_slot, act, exp);
    end
  endtask

  task automatic step(bit rq, int ln, bit il);
    logic e_busy, e_done, e_wr;
    logic [BANKS-1:0] e_stb;
    int e_idx;
    int e_addr;
    @(negedge clk);
    n_slot++;
    // expected outputs for this slot
    e_busy = 1'b0; e_done = 1'b0; e_wr = 1'b0; e_stb = '0; e_idx = 0; e_addr = 0;
    if (m_t >= 0 && m_t < m_end) begin
      e_busy = 1'b1;
      if (m_ilv == 0) begin
        e_idx = m_t / 9;
        if (m_t % 9 == 0) begin e_stb = 4'b0001; e_addr = m_line*8 + e_idx; end
        e_wr = (m_t % 9 == 8);
      end else begin
        if (m_t < 2) begin e_stb = 4'b1111; e_addr = m_line*2 + m_t; end
        if (m_t >= 9) begin e_wr = 1'b1; e_idx = m_t - 9; end
      end
    end else if (m_t == m_end) begin
      e_done = 1'b1;
    end
    chk(busy == e_busy, "R7", "busy", busy, e_busy);
    chk(done == e_done, "R7", "done", done, e_done);
    chk(cwr_en == e_wr, "R6", "cwr_en", cwr_en, e_wr);
    if (e_wr) begin
      chk(cwr_idx == 3'(e_idx), "R6", "cwr_idx", cwr_idx, e_idx);
      chk(cwr_data == memf(m_line*8 + e_idx), "R6", "cwr_data", cwr_data, memf(m_line*8 + e_idx));
    end
    chk(mem_stb == e_stb, (m_ilv != 0) ? "R4" : "R2", "mem_stb", mem_stb, e_stb);
    for (int b = 0; b < BANKS; b++) begin
      if (e_stb[b])
        chk(int'(mem_addr[b*MAW +: MAW]) == e_addr, (m_ilv != 0) ? "R4" : "R2",
            "mem_addr", mem_addr[b*MAW +: MAW], e_addr);
    end
    if (done && m_acc > 0) begin
      chk((n_slot - m_acc - 1) == m_end, (m_ilv != 0) ? "R5" : "R3", "latency",
          n_slot - m_acc - 1, m_end);
    end
    // memory: record strobes, then deliver due data
    for (int b = 0; b < BANKS; b++) begin
      if (mem_stb[b]) begin
        pend_due.push_back(n_slot + MEM_LAT);
        pend_bank.push_back(b);
        pend_g.push_back((m_ilv != 0) ? int'(mem_addr[b*MAW +: MAW])*BANKS + b
                                      : int'(mem_addr[b*MAW +: MAW]));
      end
    end
    mem_rdy   = '0;
    mem_rdata = '0;
    while (pend_due.size() > 0 && pend_due[0] == n_slot) begin
      mem_rdy[pend_bank[0]] = 1'b1;
      mem_rdata[pend_bank[0]*DW +: DW] = memf(pend_g[0]);
      void'(pend_due.pop_front());
      void'(pend_bank.pop_front());
      void'(pend_g.pop_front());
    end
    // drive request
    req_valid = rq;
    req_line  = LINE_AW'(ln);
    req_ilv   = il;
    // advance model (a request is taken only when idle or in the done slot)
    if (m_t >= 0 && m_t < m_end) begin
      m_t++;
    end else if (rq && rst_n) begin
      m_t    = 0;
      m_ilv  = il;
      m_line = ln;
      m_acc  = n_slot;
      m_end  = il ? END_I : END_P;
    end else begin
      m_t = -1;
    end
  endtask

  // one refill; inject a conflicting request mid-way when asked (R8)
  task automatic refill(int ln, bit il, bit inject, bit gap);
    step(1'b1, ln, il);
    for (int k = 0; k < 200; k++) begin
      if (m_t == m_end) break;
      if (inject && m_t == 3) step(1'b1, ln ^ 10'h155, ~il);   // R8 ignored request
      else                    step(1'b0, 0, 1'b0);
    end
    if (gap) step(1'b0, 0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_line = '0; req_ilv = 1'b0;
    mem_rdy = '0; mem_rdata = '0;
    // R1: outputs quiet in reset, a request in reset is not taken
    for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b0);
    step(1'b1, 5, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b0, 0, 1'b0);
    // R2 R3: plain refill
    refill(10'h005, 1'b0, 1'b0, 1'b1);
    // R4 R5: interleaved refill at top line
    refill(10'h3FF, 1'b1, 1'b0, 1'b1);
    // R8: requests during busy, both modes
    refill(10'h2A5, 1'b0, 1'b1, 1'b1);
    refill(10'h0C3, 1'b1, 1'b1, 1'b1);
    // R8: back-to-back acceptance in the done slot
    refill(10'h000, 1'b1, 1'b0, 1'b0);
    refill(10'h111, 1'b0, 1'b0, 1'b0);
    refill(10'h222, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) step(1'b0, 0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog slot %0d actual running expected finished", n_slot);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule